// File: doc/BRIEF.md
# One-Time-Programmable Memory Write/Verify Sequencer

This block runs on the programming host and burns a run of 16-bit words into a one-time-programmable target. The target has no address pins. Its internal address is cleared by a mode code and then moved forward by pulses on a dedicated clock pin. The target's operation is chosen by a 4-bit mode bus, and data travels over a shared 8-bit bus. The sequencer takes words one at a time from a valid/ready port.

For each word it runs an adaptive loop. The loop is: write pulse, inhibit, verify. It repeats until both bytes of the word read back correctly. Then it applies one extra write whose length grows with the number of pulses the word needed, and steps the address.

All timing is counted in system clock cycles derived from the `CLK_HZ` parameter:

- The nominal write pulse is 1 ms.
- The mode/data setup gap is 2 µs.
- The address clock phase is at least 0.125 µs.

A word that still fails after `MAX_PULSES` attempts ends the run with a failure pulse and the index of that word. A full run ends with an address-clear and a done pulse.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held, the outputs are as follows. `mode_o` carries the inhibit code. `data_oe_o`, `prog_clk_o`, `word_ready_o`, `done_o` and `fail_o` are all low.
- R2: A start request is handled as follows.
  - A start with `n_words_i` equal to zero is ignored.
  - Any other start first drives the address-clear code, then inhibit, before the first word is requested or written.
- R3: `mode_o` only ever carries one of four codes, written bit 3 down to bit 0: address-clear 0101, write 1110, verify 1100, inhibit 1111.
- R4: Write pulses and the data bus behave as follows.
  - Every regular write pulse lasts exactly `CLK_HZ/1000` cycles.
  - The data byte stays stable for the whole pulse.
  - `data_oe_o` is high whenever the write code is out, and it is never high during verify.
- R5: Each pulse round writes lane 0 (`byte_sel_o`=0, word bits 7:0) first, then lane 1 (`byte_sel_o`=1, bits 15:8). `data_o` carries the selected byte of the current word.
- R6: After every regular pulse round, the verify code is applied. Both lanes of `din_i` are compared with the word, and a mismatch in either byte starts another round.
- R7: Once verify passes after X rounds, one more round is written with each lane's pulse lasting X times `CLK_HZ/1000` cycles. No verify follows it.
- R8: After the extra round, the address moves forward with exactly four `prog_clk_o` pulses. Each pulse is high and low for at least ceil(0.125 µs) cycles, and `prog_clk_o` is high only under the inhibit code.
- R9: If verify still fails after `MAX_PULSES` rounds, the run stops with these effects.
  - `fail_o` pulses for one cycle and `fail_addr_o` holds the word index.
  - No extra round or address step follows.
  - `done_o` does not pulse.
- R10: After the last word has been stepped, the address-clear code is applied. It is followed by a one-cycle `done_o` pulse.
- R11: Every write or verify code is preceded by at least ceil(2 µs) cycles of inhibit. Every non-inhibit code is held for at least that long.
- R12: `word_ready_o` is high only while waiting for the next word, under inhibit with the data bus released. Exactly one word is consumed per address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a programming run |
| n_words_i | input | AW | Number of words in the run, sampled at start |
| word_i | input | 16 | Next word to program |
| word_valid_i | input | 1 | `word_i` is valid |
| word_ready_o | output | 1 | Sequencer accepts a word |
| mode_o | output | 4 | Target mode code |
| prog_clk_o | output | 1 | Target address-step clock |
| data_o | output | 8 | Byte driven to the target |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| byte_sel_o | output | 1 | Lane of the word on the data bus |
| din_i | input | 8 | Byte read back from the target |
| done_o | output | 1 | One-cycle pulse at the end of a passing run |
| fail_o | output | 1 | One-cycle pulse when a word exceeds the pulse limit |
| fail_addr_o | output | AW | Index of the word that failed |

## Verification
The assertions watch the following rules on every cycle:

- the address clock only pulses under inhibit;
- the write data holds still while the write code is out;
- the bus is released during verify;
- the pulse count never exceeds its limit, and a failure happens exactly at that limit;
- every address step carries four rising edges;
- the timer counts down one per cycle;
- done follows the address-clear code.

Other behaviour only the bench's scenarios can show: the length of each pulse, the proportional length of the extra pulse, the number of verify passes, the stepping of the address across words, the byte order, and the failing index. The bench shows these against a behavioural target whose cells need a chosen number of pulses before they read back correctly.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    MODE_CLEAR   = 4'b0101,
    MODE_WRITE   = 4'b1110,
    MODE_VERIFY  = 4'b1100,
    MODE_INHIBIT = 4'b1111
  } otp_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_INH,
    ST_FETCH,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_VSET,
    ST_VEND,
    ST_STEP,
    ST_FIN
  } seq_state_e;

endpackage

// File: rtl/otp_wait_timer.sv
module otp_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: pulse lengths rely on a strict one-per-cycle countdown
  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/otp_addr_stepper.sv
module otp_addr_stepper #(
  parameter int HI_CYC = 1,
  parameter int NPULSE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pin_o,
  output logic done_o
);

  localparam int PHW = $clog2(2 * NPULSE);
  localparam int TCW = $clog2(HI_CYC + 1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(2 * NPULSE - 1);
  localparam logic [TCW-1:0] TC_LOAD = TCW'(HI_CYC - 1);

  logic           busy_q, done_q;
  logic [PHW-1:0] ph_q;
  logic [TCW-1:0] tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      tc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          ph_q   <= '0;
          tc_q   <= TC_LOAD;
        end
      end else if (tc_q != '0) begin
        tc_q <= tc_q - 1'b1;
      end else if (ph_q == PH_LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
        tc_q <= TC_LOAD;
      end
    end
  end

  // even phases high, odd phases low
  assign pin_o  = busy_q & ~ph_q[0];
  assign done_o = done_q;

  logic         pin_q;
  logic [PHW:0] rises_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      rises_q <= '0;
    end else begin
      pin_q <= pin_o;
      if (start_i && !busy_q)    rises_q <= '0;
      else if (pin_o && !pin_q)  rises_q <= rises_q + 1'b1;
    end
  end

  p_four_edges_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rises_q == (PHW+1)'(NPULSE)));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int CLK_HZ     = 8_000_000,
  parameter int MAX_PULSES = 20,
  parameter int AW         = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] n_words_i,
  input  logic [15:0]   word_i,
  input  logic          word_valid_i,
  output logic          word_ready_o,
  output logic [3:0]    mode_o,
  output logic          prog_clk_o,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic          byte_sel_o,
  input  logic [7:0]    din_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);

  localparam int PULSE_CYC = CLK_HZ / 1000;
  localparam int GAP_RAW   = (2 * CLK_HZ + 999_999) / 1_000_000;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int HI_RAW    = (CLK_HZ + 7_999_999) / 8_000_000;
  localparam int HI_CYC    = (HI_RAW < 1) ? 1 : HI_RAW;
  localparam int LONG_CYC  = MAX_PULSES * PULSE_CYC;
  localparam int TW        = $clog2(LONG_CYC + 1);
  localparam int PCW       = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0]  GAP_LD   = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0]  PULSE_LD = TW'(PULSE_CYC - 1);
  localparam logic [PCW-1:0] PMAX     = PCW'(MAX_PULSES);

  seq_state_e     state_q, state_d;
  logic           lane_q, lane_d, extra_q, extra_d, miss_q, miss_d;
  logic [PCW-1:0] pulses_q, pulses_d;
  logic [AW-1:0]  addr_q, addr_d, nwords_q, nwords_d, fail_addr_q, fail_addr_d;
  logic [15:0]    word_q, word_d;
  logic           done_q, done_d, fail_q, fail_d;
  logic           tmr_load, tmr_exp, step_start, step_done;
  logic [TW-1:0]  tmr_val;
  logic [7:0]     cur_byte;
  otp_mode_e      mode;

  assign cur_byte = lane_q ? word_q[15:8] : word_q[7:0];

  otp_wait_timer #(.W(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  otp_addr_stepper #(.HI_CYC(HI_CYC), .NPULSE(4)) u_stepper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(step_start),
    .pin_o  (prog_clk_o),
    .done_o (step_done)
  );

  always_comb begin
    state_d     = state_q;
    lane_d      = lane_q;
    extra_d     = extra_q;
    miss_d      = miss_q;
    pulses_d    = pulses_q;
    addr_d      = addr_q;
    nwords_d    = nwords_q;
    word_d      = word_q;
    fail_addr_d = fail_addr_q;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = GAP_LD;
    unique case (state_q)
      ST_IDLE: if (start_i && n_words_i != '0) begin
        nwords_d = n_words_i;
        addr_d   = '0;
        state_d  = ST_CLR;
        tmr_load = 1'b1;
      end
      ST_CLR: if (tmr_exp) begin
        state_d  = ST_INH;
        tmr_load = 1'b1;
      end
      ST_INH: if (tmr_exp) state_d = ST_FETCH;
      ST_FETCH: if (word_valid_i) begin
        word_d   = word_i;
        pulses_d = '0;
        extra_d  = 1'b0;
        lane_d   = 1'b0;
        state_d  = ST_WSET;
        tmr_load = 1'b1;
      end
      ST_WSET: if (tmr_exp) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = extra_q ? (TW'(pulses_q) * TW'(PULSE_CYC) - TW'(1)) : PULSE_LD;
        if (!extra_q && !lane_q) pulses_d = pulses_q + 1'b1;
      end
      ST_WPULSE: if (tmr_exp) begin
        state_d  = ST_WHOLD;
        tmr_load = 1'b1;
      end
      ST_WHOLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (!lane_q) begin
          lane_d  = 1'b1;
          state_d = ST_WSET;
        end else begin
          lane_d  = 1'b0;
          miss_d  = 1'b0;
          state_d = extra_q ? ST_STEP : ST_VSET;
        end
      end
      ST_VSET: if (tmr_exp) begin
        miss_d   = miss_q | (din_i != cur_byte);
        tmr_load = 1'b1;
        if (!lane_q) begin
          lane_d = 1'b1;
        end else begin
          lane_d  = 1'b0;
          state_d = ST_VEND;
        end
      end
      ST_VEND: if (tmr_exp) begin
        if (!miss_q) begin
          extra_d  = 1'b1;
          state_d  = ST_WSET;
          tmr_load = 1'b1;
        end else if (pulses_q == PMAX) begin
          fail_d      = 1'b1;
          fail_addr_d = addr_q;
          state_d     = ST_IDLE;
        end else begin
          state_d  = ST_WSET;
          tmr_load = 1'b1;
        end
      end
      ST_STEP: if (step_done) begin
        addr_d = addr_q + 1'b1;
        if (addr_q + 1'b1 == nwords_q) begin
          state_d  = ST_FIN;
          tmr_load = 1'b1;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FIN: if (tmr_exp) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_start = (state_q != ST_STEP) && (state_d == ST_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lane_q      <= 1'b0;
      extra_q     <= 1'b0;
      miss_q      <= 1'b0;
      pulses_q    <= '0;
      addr_q      <= '0;
      nwords_q    <= '0;
      word_q      <= '0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      lane_q      <= lane_d;
      extra_q     <= extra_d;
      miss_q      <= miss_d;
      pulses_q    <= pulses_d;
      addr_q      <= addr_d;
      nwords_q    <= nwords_d;
      word_q      <= word_d;
      fail_addr_q <= fail_addr_d;
      done_q      <= done_d;
      fail_q      <= fail_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CLR, ST_FIN: mode = MODE_CLEAR;
      ST_WPULSE:      mode = MODE_WRITE;
      ST_VSET:        mode = MODE_VERIFY;
      default:        mode = MODE_INHIBIT;
    endcase
  end

  assign mode_o       = mode;
  assign data_o       = cur_byte;
  assign data_oe_o    = (state_q == ST_WSET) || (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign byte_sel_o   = lane_q;
  assign word_ready_o = (state_q == ST_FETCH);
  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_addr_o  = fail_addr_q;

  p_clk_inhibit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_clk_o |-> (mode == MODE_INHIBIT));

  p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WRITE) |=> (mode != MODE_WRITE || $stable(data_o)));

  p_verify_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_VERIFY) |-> !data_oe_o);

  p_pulse_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_q <= PMAX);

  p_fail_at_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |-> (pulses_q == PMAX));

  p_done_after_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(mode) == MODE_CLEAR));

endmodule

// File: tb/otp_prog_seq_bench.sv
`timescale 1ns/1ps
module otp_prog_seq_bench;

  localparam int CLK_HZ = 2_000_000;
  localparam int MAXP   = 4;
  localparam int AW     = 13;
  localparam int PULSE  = CLK_HZ / 1000;
  localparam int GAP    = (2 * CLK_HZ + 999_999) / 1_000_000;
  localparam int HIC    = 1;
  localparam logic [3:0] MD_CLR = 4'b0101;
  localparam logic [3:0] MD_WR  = 4'b1110;
  localparam logic [3:0] MD_VER = 4'b1100;
  localparam logic [3:0] MD_INH = 4'b1111;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] n_words = '0;
  logic [15:0]   word = '0;
  logic          word_valid = 1'b0;
  logic          word_ready, prog_clk, data_oe, byte_sel, done, fail;
  logic [3:0]    mode;
  logic [7:0]    data, din;
  logic [AW-1:0] fail_addr;

  always #2 clk = ~clk;

  otp_prog_seq #(.CLK_HZ(CLK_HZ), .MAX_PULSES(MAXP), .AW(AW)) u_otp_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_words_i(n_words),
    .word_i(word), .word_valid_i(word_valid), .word_ready_o(word_ready),
    .mode_o(mode), .prog_clk_o(prog_clk), .data_o(data), .data_oe_o(data_oe),
    .byte_sel_o(byte_sel), .din_i(din), .done_o(done), .fail_o(fail),
    .fail_addr_o(fail_addr)
  );

  // behavioural target: cells read back correctly only after need[] pulses
  int          need [2][4];
  logic [15:0] wexp [2][4];
  int          run_no = 0;
  int          wcnt [2][4][2];
  logic [7:0]  lat  [2][4][2];
  int          vcnt [2];
  int          clk_pulses [2];
  int          m_addr = 0, fall_cnt = 0, mrun = 0, wlen = 0;
  logic [3:0]  pmode = MD_INH, last_act = MD_INH;
  logic        pclk = 1'b0, cleared = 1'b0, wlane = 1'b0;
  logic [7:0]  pdata = '0;
  int          m_checks = 0, m_errs = 0, t_checks = 0, t_errs = 0;

  initial begin
    for (int r = 0; r < 2; r++) begin
      vcnt[r] = 0;
      clk_pulses[r] = 0;
      for (int a = 0; a < 4; a++) begin
        need[r][a] = 1;
        wexp[r][a] = '0;
        for (int l = 0; l < 2; l++) begin
          wcnt[r][a][l] = 0;
          lat[r][a][l] = '0;
        end
      end
    end
  end

  always_comb begin
    din = 8'h00;
    if (mode == MD_VER && m_addr >= 0 && m_addr < 4) begin
      if (wcnt[run_no][m_addr][byte_sel] >= need[run_no][m_addr])
        din = lat[run_no][m_addr][byte_sel];
      else
        din = ~lat[run_no][m_addr][byte_sel];
    end
  end

  task automatic m_chk(input bit ok, input string req, input string what, input int act, input int exp);
    m_checks++;
    if (!ok) begin
      m_errs++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_chk(input bit ok, input string req, input string what, input int act, input int exp);
    t_checks++;
    if (!ok) begin
      t_errs++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      m_chk(mode == MD_CLR || mode == MD_WR || mode == MD_VER || mode == MD_INH, "R3", "mode code", int'(mode), int'(MD_INH));
      if (data_oe) m_chk(mode != MD_VER, "R4", "bus driven in verify", int'(mode), int'(MD_INH));
      if (mode == MD_WR) m_chk(data_oe, "R4", "write without drive", int'(data_oe), 1);
      if (prog_clk) m_chk(mode == MD_INH, "R8", "address clock outside inhibit", int'(mode), int'(MD_INH));
      if (word_ready) m_chk(mode == MD_INH && !data_oe, "R12", "ready outside fetch", int'(mode), int'(MD_INH));
      if (mode == MD_WR && pmode == MD_WR) m_chk(data == pdata, "R4", "data moved in pulse", int'(data), int'(pdata));
      if (mode != pmode) begin
        if (pmode != MD_INH || mode == MD_WR || mode == MD_VER)
          m_chk(mrun >= GAP, "R11", "mode held too briefly", mrun, GAP);
        if (pmode == MD_WR && m_addr < 4) begin
          int k, n, expw;
          k = wcnt[run_no][m_addr][wlane] - 1;
          n = need[run_no][m_addr];
          if (k < n && k < MAXP) begin
            m_chk(wlen == PULSE, "R4", "regular pulse width", wlen, PULSE);
          end else begin
            expw = (k == n && n <= MAXP) ? n * PULSE : 0;
            m_chk(wlen == expw, "R7", "extra pulse width", wlen, expw);
          end
        end
        if (mode == MD_WR) begin
          m_chk(cleared, "R2", "write before address clear", int'(cleared), 1);
          if (m_addr < 4) begin
            lat[run_no][m_addr][byte_sel] = data;
            wcnt[run_no][m_addr][byte_sel]++;
            m_chk(data == (byte_sel ? wexp[run_no][m_addr][15:8] : wexp[run_no][m_addr][7:0]),
                  "R5", "lane byte", int'(data), int'(byte_sel ? wexp[run_no][m_addr][15:8] : wexp[run_no][m_addr][7:0]));
            if (byte_sel)
              m_chk(wcnt[run_no][m_addr][1] == wcnt[run_no][m_addr][0], "R5", "lane order", wcnt[run_no][m_addr][1], wcnt[run_no][m_addr][0]);
          end else begin
            m_chk(1'b0, "R12", "write beyond run", m_addr, 3);
          end
          wlen  = 0;
          wlane = byte_sel;
        end
        if (mode == MD_VER) vcnt[run_no]++;
        if (mode == MD_CLR) begin
          m_addr   = 0;
          fall_cnt = 0;
          cleared  = 1'b1;
        end
        if (mode != MD_INH) last_act = mode;
        mrun = 0;
      end
      mrun++;
      if (mode == MD_WR) wlen++;
      if (pclk && !prog_clk) begin
        if (fall_cnt % 4 == 2) m_addr++;
        fall_cnt++;
      end
      if (!pclk && prog_clk) clk_pulses[run_no]++;
      pmode = mode;
      pclk  = prog_clk;
      pdata = data;
    end
  end

  task automatic kick(input int n);
    @(negedge clk);
    start   = 1'b1;
    n_words = AW'(n);
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!word_ready);
      word       = wexp[run_no][i];
      word_valid = 1'b1;
      @(negedge clk);
      word_valid = 1'b0;
    end
  endtask

  bit got_done, got_fail, wd;

  task automatic wait_end();
    got_done = 0;
    got_fail = 0;
    while (!done && !fail) @(negedge clk);
    got_done = done;
    got_fail = fail;
    if (done) t_chk(last_act == MD_CLR, "R10", "mode before done", int'(last_act), int'(MD_CLR));
    @(negedge clk);
    t_chk(!done && !fail, "R10", "end pulse width", int'(done) + int'(fail), 0);
  endtask

  task automatic scenario();
    bit moved;
    repeat (3) @(negedge clk);
    t_chk(mode == MD_INH, "R1", "reset mode", int'(mode), int'(MD_INH));
    t_chk(!data_oe && !prog_clk && !word_ready, "R1", "reset strobes", int'(data_oe) + int'(prog_clk) + int'(word_ready), 0);
    t_chk(!done && !fail, "R1", "reset result", int'(done) + int'(fail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // zero-length start is ignored
    kick(0);
    moved = 0;
    repeat (20) begin
      @(negedge clk);
      if (mode != MD_INH || word_ready) moved = 1;
    end
    t_chk(!moved, "R2", "zero-word start ignored", int'(moved), 0);

    // run 0: all words pass, one at the pulse limit
    run_no = 0;
    need[0][0] = 1; wexp[0][0] = 16'hA53C;
    need[0][1] = 4; wexp[0][1] = 16'h0F81;
    need[0][2] = 2; wexp[0][2] = 16'h7E42;
    kick(3);
    while (mode == MD_INH) @(negedge clk);
    t_chk(mode == MD_CLR, "R2", "first mode after start", int'(mode), int'(MD_CLR));
    fork
      feed(3);
      wait_end();
    join
    t_chk(got_done && !got_fail, "R10", "run 0 completes", int'(got_done), 1);
    for (int a = 0; a < 3; a++)
      for (int l = 0; l < 2; l++) begin
        t_chk(wcnt[0][a][l] == need[0][a] + 1, "R7", "pulses incl. extra", wcnt[0][a][l], need[0][a] + 1);
        t_chk(lat[0][a][l] == (l == 1 ? wexp[0][a][15:8] : wexp[0][a][7:0]), "R5", "stored byte",
              int'(lat[0][a][l]), int'(l == 1 ? wexp[0][a][15:8] : wexp[0][a][7:0]));
      end
    t_chk(vcnt[0] == 7, "R6", "verify passes run 0", vcnt[0], 7);
    t_chk(clk_pulses[0] == 12, "R8", "address clocks run 0", clk_pulses[0], 12);
    t_chk(mode == MD_INH && !word_ready, "R12", "idle after run 0", int'(word_ready), 0);

    // run 1: second word never verifies
    run_no = 1;
    need[1][0] = 2; wexp[1][0] = 16'h1234;
    need[1][1] = 9; wexp[1][1] = 16'hC3E7;
    repeat (5) @(negedge clk);
    kick(2);
    fork
      feed(2);
      wait_end();
    join
    t_chk(got_fail && !got_done, "R9", "run 1 fails", int'(got_fail), 1);
    t_chk(fail_addr == AW'(1), "R9", "failing index", int'(fail_addr), 1);
    t_chk(wcnt[1][1][0] == MAXP && wcnt[1][1][1] == MAXP, "R9", "pulses at limit", wcnt[1][1][0], MAXP);
    t_chk(wcnt[1][0][0] == 3 && wcnt[1][0][1] == 3, "R7", "first word extra", wcnt[1][0][0], 3);
    t_chk(vcnt[1] == 6, "R6", "verify passes run 1", vcnt[1], 6);
    t_chk(clk_pulses[1] == 4, "R9", "no step after fail", clk_pulses[1], 4);
    repeat (10) @(negedge clk);
    t_chk(mode == MD_INH && !done, "R9", "idle after fail", int'(mode), int'(MD_INH));
  endtask

  initial begin
    wd = 0;
    fork
      scenario();
      begin
        repeat (180_000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      t_checks++;
      t_errs++;
      $display("FAIL R10: watchdog expired actual=%0d expected=%0d", 1, 0);
    end
    $display("CHECKS %0d ERRORS %0d", t_checks + m_checks, t_errs + m_errs);
    $finish;
  end

endmodule